// File: doc/BRIEF.md
# Masked Packed Integer-to-Single Converter

This block takes a vector of signed 64-bit integer lanes and turns each one into an IEEE-754 binary32 value. The results are packed into a destination that is half the width of the source. A two-bit length select picks how many lanes take part: two, four or eight. Each lane can be gated by a mask bit. A lane that is gated off either keeps the caller's old destination value or is forced to zero. A broadcast option feeds the lowest source element to every lane.

Every lane is rounded under one of four rounding modes. For the widest length, a per-operation override can replace the default mode. An inexact flag reports whether any converted lane lost precision. The outputs are registered: they appear one cycle after a valid strobe and hold between strobes.

Top module: `packcvt`

## Requirements
- R1: `vlen` encodes the active lane count: 2'b00 gives 2 lanes, 2'b01 gives 4 lanes, and 2'b10 or 2'b11 gives 8 lanes. Active lane j reads `src[64j+63:64j]` and writes `dst[32j+31:32j]`.
- R2: Every `dst` bit at or above position 32 times the active lane count is zero after a strobe, whatever the masking mode.
- R3: A converted lane holds the binary32 encoding of its two's-complement input. This is sign in bit 31, biased exponent in bits 30:23 and fraction in bits 22:0. A zero input gives 32'h0000_0000.
- R4: The rounding-mode code selects the rounding: 2'b00 is nearest with ties to even, 2'b01 is toward minus infinity, 2'b10 is toward plus infinity and 2'b11 is toward zero.
- R5: The mode in use is `rm_ovr` when `rm_ovr_en` is 1 and `vlen[1]` is 1 (eight lanes). Otherwise the mode is `rm_def`.
- R6: With `mask_en` low, every active lane is converted. With `mask_en` high, active lane j is converted only when `mask[j]` is 1.
- R7: An active lane that is not converted takes the matching `old_dst` lane when `zero_mask` is 0, and 32'h0 when `zero_mask` is 1.
- R8: With `bcast` high, every converted lane uses `src[63:0]` in place of its own element.
- R9: `inexact` is 1 exactly when at least one converted lane discarded nonzero bits. Masked-off lanes and lanes outside the active length never set it.
- R10: `out_valid` equals `in_valid` one cycle later. `dst` and `inexact` update only on cycles with `in_valid` high and hold otherwise.
- R11: While `rst` is high at a clock edge, `out_valid`, `dst` and `inexact` become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 512 | Eight signed 64-bit integer lanes |
| old_dst | input | 256 | Previous destination, used for merge masking |
| mask | input | 8 | Per-lane enable |
| mask_en | input | 1 | 1 applies `mask`, 0 converts all active lanes |
| zero_mask | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| bcast | input | 1 | Use the lowest element for every lane |
| vlen | input | 2 | Vector length select |
| rm_def | input | 2 | Default rounding mode |
| rm_ovr_en | input | 1 | Request a rounding override |
| rm_ovr | input | 2 | Override rounding mode |
| out_valid | output | 1 | Result strobe |
| dst | output | 256 | Packed binary32 results |
| inexact | output | 1 | Precision-loss flag |

## Verification
The hardest cases to reach from the ports are exact halfway ties under nearest-even rounding, and rounding carries that ripple from the fraction into the exponent. Random 64-bit inputs almost never land on either. The stimulus therefore builds operands as a power of two plus a small offset, with directed values such as 2^25+2, 2^25+6 and 2^24-1 plus all-ones fractions. It also uses extreme values like the most negative integer. These operands are mixed with random masks, lengths, broadcast and override settings, so that an inexact lane which is masked off or lies outside the active length is also exercised.

// File: rtl/packcvt_pkg.sv
package packcvt_pkg;
  localparam int FP_MANT = 23;
  localparam int FP_BIAS = 127;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rm_t;
endpackage

// File: rtl/packcvt_lzc.sv
module packcvt_lzc #(
  parameter int W = 64,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt,
  output logic          none
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) cnt = CW'(W - 1 - i);
    end
  end

  assign none = ~|vec;
endmodule

// File: rtl/packcvt_lane.sv
module packcvt_lane
  import packcvt_pkg::*;
#(
  parameter int IW = 64
) (
  input  logic [IW-1:0] ival,
  input  rm_t           rmode,
  output logic [31:0]   fval,
  output logic          inexact
);
  localparam int CW = $clog2(IW);

  logic              sgn;
  logic [IW-1:0]     mag;
  logic [IW-1:0]     norm;
  logic [CW-1:0]     lz;
  logic              is_zero;
  logic [7:0]        bexp;
  logic [FP_MANT-1:0] frac;
  logic              guard, sticky, lsb, rup;

  assign sgn = ival[IW-1];
  assign mag = sgn ? (~ival + 1'b1) : ival;

  packcvt_lzc #(.W(IW)) u_lzc (
    .vec (mag),
    .cnt (lz),
    .none(is_zero)
  );

  assign norm   = mag << lz;
  assign frac   = norm[IW-2 -: FP_MANT];
  assign lsb    = norm[IW-1-FP_MANT];
  assign guard  = norm[IW-2-FP_MANT];
  assign sticky = |norm[IW-3-FP_MANT:0];
  assign bexp   = 8'(FP_BIAS + IW - 1) - 8'(lz);

  always_comb begin
    unique case (rmode)
      RM_NEAR: rup = guard & (sticky | lsb);
      RM_DOWN: rup = (guard | sticky) & sgn;
      RM_UP:   rup = (guard | sticky) & ~sgn;
      default: rup = 1'b0;
    endcase
  end

  // carry out of the fraction ripples into the exponent field
  assign fval    = is_zero ? 32'h0 : ({sgn, bexp, frac} + 32'(rup));
  assign inexact = guard | sticky;

  always_comb begin
    // R3
    norm_lead_chk: assert (is_zero || norm[IW-1]);
    // R3
    zero_res_chk: assert (ival != '0 || fval == 32'h0);
    // R9
    small_exact_chk: assert (mag[IW-1:FP_MANT+1] != '0 || !inexact);
  end
endmodule

// File: rtl/packcvt.sv
module packcvt
  import packcvt_pkg::*;
#(
  parameter int LANES = 8,
  parameter int IW    = 64,
  parameter int OW    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*IW-1:0] src,
  input  logic [LANES*OW-1:0] old_dst,
  input  logic [LANES-1:0]    mask,
  input  logic                mask_en,
  input  logic                zero_mask,
  input  logic                bcast,
  input  logic [1:0]          vlen,
  input  logic [1:0]          rm_def,
  input  logic                rm_ovr_en,
  input  logic [1:0]          rm_ovr,
  output logic                out_valid,
  output logic [LANES*OW-1:0] dst,
  output logic                inexact
);
  localparam int CNT_W = $clog2(LANES) + 1;

  logic [CNT_W-1:0]    act;
  rm_t                 rm_sel;
  logic [LANES*OW-1:0] dst_nxt;
  logic [LANES-1:0]    inx_v;

  always_comb begin
    unique case (vlen)
      2'b00:   act = CNT_W'(2);
      2'b01:   act = CNT_W'(4);
      default: act = CNT_W'(LANES);
    endcase
  end

  assign rm_sel = rm_t'((rm_ovr_en && vlen[1]) ? rm_ovr : rm_def);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [IW-1:0] lin;
    logic [OW-1:0] lres;
    logic          linx, in_len, conv;

    assign lin    = bcast ? src[IW-1:0] : src[j*IW +: IW];
    assign in_len = (CNT_W'(j) < act);
    assign conv   = in_len && (!mask_en || mask[j]);

    packcvt_lane #(.IW(IW)) u_lane (
      .ival   (lin),
      .rmode  (rm_sel),
      .fval   (lres),
      .inexact(linx)
    );

    always_comb begin
      if (!in_len)        dst_nxt[j*OW +: OW] = '0;
      else if (conv)      dst_nxt[j*OW +: OW] = lres;
      else if (zero_mask) dst_nxt[j*OW +: OW] = '0;
      else                dst_nxt[j*OW +: OW] = old_dst[j*OW +: OW];
    end
    assign inx_v[j] = conv & linx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      dst       <= '0;
      inexact   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        dst     <= dst_nxt;
        inexact <= |inx_v;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R10
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && $stable(dst) && $stable(inexact));
  // R2
  upper_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen == 2'b00) |=> dst[LANES*OW-1:2*OW] == '0);
  // R7
  zero_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && zero_mask && !mask[0]) |=> dst[OW-1:0] == '0);
  // R7
  merge_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && !zero_mask && !mask[0]) |=> dst[OW-1:0] == $past(old_dst[OW-1:0]));
  // R9
  no_inexact_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_en && mask == '0) |=> !inexact);
endmodule

// File: tb/sim_packcvt.sv
module sim_packcvt;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic [511:0] src;
  logic [255:0] old_dst;
  logic [7:0] mask;
  logic mask_en, zero_mask, bcast, rm_ovr_en;
  logic [1:0] vlen, rm_def, rm_ovr;
  logic out_valid, inexact;
  logic [255:0] dst;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic e_valid, e_inx;
  logic [255:0] e_dst;

  always #(CLK_P/2) clk = ~clk;

  packcvt u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .old_dst(old_dst),
    .mask(mask), .mask_en(mask_en), .zero_mask(zero_mask), .bcast(bcast),
    .vlen(vlen), .rm_def(rm_def), .rm_ovr_en(rm_ovr_en), .rm_ovr(rm_ovr),
    .out_valid(out_valid), .dst(dst), .inexact(inexact)
  );

  function automatic logic [31:0] ref_cvt(input logic [63:0] x, input logic [1:0] m,
                                          output logic inx);
    logic s, up;
    logic [63:0] mag, kept, rem, half;
    int p;
    s = x[63];
    mag = s ? (~x + 64'd1) : x;
    inx = 1'b0;
    if (mag == 64'd0) return 32'h0;
    p = 0;
    for (int b = 0; b < 64; b++) if (mag[b]) p = b;
    if (p <= 23) begin
      kept = mag << (23 - p); rem = 0; half = 0;
    end else begin
      kept = mag >> (p - 23);
      rem  = mag - (kept << (p - 23));
      half = 64'd1 << (p - 24);
    end
    inx = (rem != 0);
    case (m)
      2'b00:   up = (rem > half) || (rem != 0 && rem == half && kept[0]);
      2'b01:   up = inx && s;
      2'b10:   up = inx && !s;
      default: up = 1'b0;
    endcase
    return {s, 8'(127 + p), kept[22:0]} + 32'(up);
  endfunction

  task automatic model_edge();
    int lanes;
    logic [1:0] m;
    logic li;
    logic [63:0] op;
    if (rst) begin
      e_valid = 0; e_dst = '0; e_inx = 0;
      return;
    end
    e_valid = in_valid;
    if (!in_valid) return;
    lanes = (vlen == 2'b00) ? 2 : (vlen == 2'b01) ? 4 : 8;
    m = (rm_ovr_en && lanes == 8) ? rm_ovr : rm_def;
    e_inx = 0;
    for (int j = 0; j < 8; j++) begin
      if (j >= lanes) e_dst[j*32 +: 32] = 32'h0;
      else if (!mask_en || mask[j]) begin
        op = bcast ? src[63:0] : src[j*64 +: 64];
        e_dst[j*32 +: 32] = ref_cvt(op, m, li);
        e_inx = e_inx | li;
      end else if (zero_mask) e_dst[j*32 +: 32] = 32'h0;
      else e_dst[j*32 +: 32] = old_dst[j*32 +: 32];
    end
  endtask

  task automatic cycle(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (out_valid !== e_valid) begin
      failures++;
      $display("FAIL %s out_valid actual %b expected %b", tag, out_valid, e_valid);
    end
    checks++;
    if (dst !== e_dst) begin
      failures++;
      $display("FAIL %s dst actual %h expected %h", tag, dst, e_dst);
    end
    checks++;
    if (inexact !== e_inx) begin
      failures++;
      $display("FAIL %s inexact actual %b expected %b", tag, inexact, e_inx);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; src = '0; old_dst = '0; mask = '0; mask_en = 0; zero_mask = 0;
    bcast = 0; vlen = 2'b10; rm_def = 2'b00; rm_ovr_en = 0; rm_ovr = 2'b00;
  endtask

  function automatic logic [63:0] rnd64();
    logic [63:0] v;
    case ($urandom % 7)
      0: v = {$urandom, $urandom};
      1: v = 64'(signed'($urandom % 2000000) - 1000000);
      2: v = (64'd1 << ($urandom % 63)) + 64'($urandom % 8);
      3: v = -((64'd1 << ($urandom % 63)) + 64'($urandom % 8));
      4: v = 64'h8000_0000_0000_0000;
      5: v = 64'h0;
      default: v = (64'd1 << (24 + $urandom % 30)) - 64'd1;
    endcase
    return v;
  endfunction

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      failures++;
      $display("FAIL R10 watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    e_valid = 0; e_dst = '0; e_inx = 0;
    rst = 1;
    @(negedge clk);
    cycle("R11"); cycle("R11");
    rst = 0;

    // R1 / R2: two-lane length, upper lanes cleared despite merge data
    in_valid = 1; vlen = 2'b00; old_dst = {8{32'hDEAD_BEEF}};
    for (int j = 0; j < 8; j++) src[j*64 +: 64] = 64'(j + 1);
    cycle("R1"); cycle("R2");
    vlen = 2'b01; mask_en = 1; mask = 8'h00; cycle("R2");
    vlen = 2'b11; mask_en = 0; cycle("R1");

    // R3: signed extremes and zero
    src[63:0] = 64'hFFFF_FFFF_FFFF_FFFF; src[127:64] = 64'h8000_0000_0000_0000;
    src[191:128] = 64'h7FFF_FFFF_FFFF_FFFF; src[255:192] = 64'h0;
    src[319:256] = 64'd16777215; src[383:320] = 64'd16777217;
    src[447:384] = 64'hFFFF_FFFF_FF00_0001; src[511:448] = 64'd33554434;
    cycle("R3");

    // R4: each rounding mode on inexact and tie operands
    src[63:0] = 64'd33554433; src[127:64] = -64'd33554433;
    src[191:128] = 64'd33554438; src[255:192] = 64'd33554434;
    src[319:256] = 64'h00FF_FFFF_F000_0000; src[383:320] = -64'd16777219;
    for (int r = 0; r < 4; r++) begin
      rm_def = 2'(r); cycle("R4");
    end

    // R5: override honoured only at eight lanes
    rm_def = 2'b11; rm_ovr_en = 1; rm_ovr = 2'b10; vlen = 2'b01; cycle("R5");
    vlen = 2'b10; cycle("R5");
    rm_ovr = 2'b01; vlen = 2'b00; cycle("R5");
    rm_ovr_en = 0; rm_def = 2'b00; vlen = 2'b10;

    // R6 / R7: mask patterns, merge then zero
    mask_en = 1; mask = 8'b1010_0101; zero_mask = 0;
    old_dst = {32'h1111_1111, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444,
               32'h5555_5555, 32'h6666_6666, 32'h7777_7777, 32'h8888_8888};
    cycle("R6"); cycle("R7");
    zero_mask = 1; mask = 8'b0101_1010; cycle("R7");
    mask_en = 0; cycle("R6");

    // R8: broadcast lowest element, with masking
    bcast = 1; src[63:0] = -64'd123456789012; mask_en = 1; mask = 8'b1100_0011;
    zero_mask = 0; cycle("R8");
    mask_en = 0; cycle("R8"); bcast = 0;

    // R9: only a masked-off lane or an out-of-length lane is inexact
    src = '0; src[127:64] = 64'd33554433; mask_en = 1; mask = 8'b1111_1101; cycle("R9");
    mask_en = 0; src[127:64] = 0; src[511:448] = 64'd33554433; vlen = 2'b01; cycle("R9");
    vlen = 2'b10; cycle("R9");

    // R10: no strobe means hold even when inputs move
    in_valid = 0; src = {8{64'd99999999}}; vlen = 2'b00; cycle("R10"); cycle("R10");
    in_valid = 1; cycle("R10");

    // mixed random traffic, rare ties come from the operand shapes
    for (int n = 0; n < 600; n++) begin
      in_valid = ($urandom % 5) != 0;
      for (int j = 0; j < 8; j++) src[j*64 +: 64] = rnd64();
      old_dst = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      mask = 8'($urandom); mask_en = 1'($urandom); zero_mask = 1'($urandom);
      bcast = ($urandom % 4) == 0; vlen = 2'($urandom); rm_def = 2'($urandom);
      rm_ovr_en = 1'($urandom); rm_ovr = 2'($urandom);
      cycle("R3");
    end

    // R11: reset mid-stream clears outputs
    rst = 1; cycle("R11"); rst = 0; in_valid = 0; cycle("R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule